// File: doc/BRIEF.md
# Dual Bi-Quinary Decade Counter

The block holds two counter units that run off one system clock. Each unit has a one-bit toggle stage and a separate modulo-5 stage. Each stage has its own count input, and each stage advances once for every falling transition seen on that input. The count inputs are treated as asynchronous. They pass through a two-flop synchronizer, and a falling-edge detector turns each high-to-low transition into a one-cycle increment strobe. Stages never clock other stages: every internal cascade is expressed as a strobe in the same clock domain.

A 2-bit mode per unit sets how the two stages are linked:
- **BCD decade.** The toggle stage carries into the modulo-5 stage, so the unit counts 0 to 9 in BCD.
- **Bi-quinary.** The modulo-5 stage wraps into the toggle stage, so the toggle bit is a square wave at one tenth of the input rate.
- **Independent.** The two stages count on their own.

An active-high clear per unit holds that unit at zero. Each unit also raises a one-cycle terminal pulse when it returns from its last state to zero. A link input lets that pulse from unit 0 drive unit 1, which gives a divide-by-100 chain.

Top module: `dual_biquinary_counter`

## Requirements
- R1: While `rst_ni` is low, every `q_o` bit and every `tc_o` bit is 0.
- R2: In mode 00, bit 0 of a unit's nibble (the toggle stage) inverts once for each falling transition of that unit's `cnt_a_i` bit. A rising transition leaves it unchanged.
- R3: In mode 00, bits 3:1 of the nibble (the modulo-5 stage) step in binary through 0,1,2,3,4 and then back to 0, once for each falling transition of `cnt_b_i`. These bits never hold 5, 6 or 7.
- R4: In mode 01, falling transitions of `cnt_a_i` make the nibble count 0 to 9 in BCD (bit 0 least significant) and then wrap to 0. `cnt_b_i` has no effect in this mode.
- R5: In mode 10, falling transitions of `cnt_b_i` step bits 3:1 through 0 to 4. Bit 0 inverts each time bits 3:1 wrap from 4 to 0. `cnt_a_i` has no effect in this mode.
- R6: While a unit's `clr_i` bit is high, its nibble reads 0 from the next cycle onward. Clear wins over a count strobe in the same cycle, and that strobe is lost.
- R7: `tc_o[u]` is high for exactly one cycle when unit u returns to 0 from 9 (mode 01) or from the state with bit 0 = 1 and bits 3:1 = 4 (mode 10). It is high in the first cycle in which the nibble reads 0.
- R8: Mode 11 behaves exactly as mode 00. `tc_o` stays low in modes 00 and 11.
- R9: While `link_i` is 1, the external count inputs of unit 1 are ignored. Unit 1 receives one strobe on both of its stage inputs in the cycle after each `tc_o[0]` pulse.
- R10: Count inputs, clear and mode of one unit have no effect on the other unit unless `link_i` is 1.
- R11: A falling transition of a count input that is first sampled at rising edge k changes the nibble at rising edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_a_i | input | 2 | Count input of the toggle stage, one bit per unit |
| cnt_b_i | input | 2 | Count input of the modulo-5 stage, one bit per unit |
| clr_i | input | 2 | Synchronous clear, active high, one bit per unit |
| mode_i | input | 4 | Per-unit stage linking, bits [2u+1:2u]: 00 independent, 01 BCD, 10 bi-quinary, 11 as 00 |
| link_i | input | 1 | Drive unit 1 from the terminal pulse of unit 0 |
| q_o | output | 8 | Per-unit nibble, bits [4u+3:4u]: bit 0 toggle stage, bits 3:1 modulo-5 count |
| tc_o | output | 2 | Per-unit terminal pulse |

## Verification
A count input falls between clock edges. The nibble settles on the third rising edge after that point, and the terminal pulse of the same unit rises on that edge too. A linked unit 1 moves one edge later still. The bench therefore holds each input level for several cycles and samples at falling clock edges. Over a six-cycle window after every stimulus it counts how many cycles each `tc_o` bit is high, and only then compares the nibbles with the model.

A directed case samples at the first, second and third falling clock edge after a transition to pin down that latency. Another directed case lines a strobe up with a held clear to show that the clear wins.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT = 2'b00,
    MODE_BCD   = 2'b01,
    MODE_BIQ   = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  localparam int unsigned QUIN_W    = 3;
  localparam int unsigned QUIN_LAST = 4;
  localparam int unsigned NIB_W     = QUIN_W + 1;
endpackage

// File: rtl/dbq_fall_sync.sv
module dbq_fall_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // reset to 0 so a high input at reset release makes no false strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], d_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/dbq_quin.sv
module dbq_quin
  import dbq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              stb_i,
  output logic [QUIN_W-1:0] q_o
);
  logic [QUIN_W-1:0] q_q;

  // any state at or above the last one returns to 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (clr_i)  q_q <= '0;
    else if (stb_i)  q_q <= (q_q >= QUIN_W'(QUIN_LAST)) ? '0 : q_q + 1'b1;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dbq_unit.sv
module dbq_unit
  import dbq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [1:0]       mode_i,
  input  logic             stb_a_i,
  input  logic             stb_b_i,
  output logic [NIB_W-1:0] q_o,
  output logic             tc_o
);
  mode_e             mode_eff;
  logic              bit_q;
  logic [QUIN_W-1:0] quin;
  logic              stb_bit, stb_quin, quin_wrap, tc_d, tc_q;

  assign mode_eff = (mode_i == MODE_RSVD) ? MODE_SPLIT : mode_e'(mode_i);

  assign stb_quin  = (mode_eff == MODE_BCD) ? (stb_a_i & bit_q) : stb_b_i;
  assign quin_wrap = stb_quin & quin[QUIN_W-1];
  assign stb_bit   = (mode_eff == MODE_BIQ) ? quin_wrap : stb_a_i;

  always_comb begin
    unique case (mode_eff)
      MODE_BCD: tc_d = quin_wrap;
      MODE_BIQ: tc_d = quin_wrap & bit_q;
      default:  tc_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bit_q <= 1'b0;
    else if (clr_i)    bit_q <= 1'b0;
    else if (stb_bit)  bit_q <= ~bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tc_q <= 1'b0;
    else if (clr_i)  tc_q <= 1'b0;
    else             tc_q <= tc_d;
  end

  dbq_quin u_quin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .stb_i  (stb_quin),
    .q_o    (quin)
  );

  assign q_o  = {quin, bit_q};
  assign tc_o = tc_q;
endmodule

// File: rtl/dual_biquinary_counter.sv
module dual_biquinary_counter
  import dbq_pkg::*;
#(
  parameter int unsigned NUM_UNITS   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_UNITS-1:0]       cnt_a_i,
  input  logic [NUM_UNITS-1:0]       cnt_b_i,
  input  logic [NUM_UNITS-1:0]       clr_i,
  input  logic [2*NUM_UNITS-1:0]     mode_i,
  input  logic [NUM_UNITS-2:0]       link_i,
  output logic [NIB_W*NUM_UNITS-1:0] q_o,
  output logic [NUM_UNITS-1:0]       tc_o
);
  logic [NUM_UNITS-1:0] fall_a, fall_b, stb_a, stb_b, tc_w;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    dbq_fall_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_a (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (cnt_a_i[u]), .fall_o (fall_a[u])
    );
    dbq_fall_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_b (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (cnt_b_i[u]), .fall_o (fall_b[u])
    );

    if (u == 0) begin : g_head
      assign stb_a[u] = fall_a[u];
      assign stb_b[u] = fall_b[u];
    end else begin : g_chain
      assign stb_a[u] = link_i[u-1] ? tc_w[u-1] : fall_a[u];
      assign stb_b[u] = link_i[u-1] ? tc_w[u-1] : fall_b[u];
    end

    dbq_unit u_unit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i[u]),
      .mode_i  (mode_i[2*u +: 2]),
      .stb_a_i (stb_a[u]),
      .stb_b_i (stb_b[u]),
      .q_o     (q_o[NIB_W*u +: NIB_W]),
      .tc_o    (tc_w[u])
    );
  end

  assign tc_o = tc_w;
endmodule

// File: rtl/dbq_checker.sv
module dbq_checker #(
  parameter int unsigned NUM_UNITS = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_UNITS-1:0]   clr_i,
  input logic [2*NUM_UNITS-1:0] mode_i,
  input logic [4*NUM_UNITS-1:0] q_o,
  input logic [NUM_UNITS-1:0]   tc_o
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    assert_clear_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[u] |=> (q_o[4*u +: 4] == 4'd0) && !tc_o[u]);

    assert_quin_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_o[4*u+1 +: 3] <= 3'd4);

    assert_tc_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_o[u] |=> !tc_o[u]);

    assert_tc_at_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_o[u] |-> (q_o[4*u +: 4] == 4'd0));

    assert_split_no_tc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[2*u +: 2] == 2'b00 || mode_i[2*u +: 2] == 2'b11) |=> !tc_o[u]);
  end
endmodule

bind dual_biquinary_counter dbq_checker #(.NUM_UNITS(NUM_UNITS)) u_dbq_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_i  (clr_i),
  .mode_i (mode_i),
  .q_o    (q_o),
  .tc_o   (tc_o)
);

// File: tb/dual_biquinary_counter_test.sv
module dual_biquinary_counter_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cnt_a_i = '0, cnt_b_i = '0, clr_i = '0, tc_o;
  logic [3:0] mode_i = '0;
  logic [0:0] link_i = '0;
  logic [7:0] q_o;

  int total = 0, bad = 0;
  int m_bit[2], m_quin[2], tc_seen[2];
  bit finished = 0;

  always #10 clk = ~clk;

  dual_biquinary_counter uut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_a_i(cnt_a_i), .cnt_b_i(cnt_b_i),
    .clr_i(clr_i), .mode_i(mode_i), .link_i(link_i), .q_o(q_o), .tc_o(tc_o)
  );

  function automatic logic [3:0] exp_nib(int u);
    return 4'((m_quin[u] << 1) | m_bit[u]);
  endfunction

  function automatic string mode_tag(int u);
    case (mode_i[2*u +: 2])
      2'b00: return "R2";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // reference step of one stage input of one unit
  task automatic m_step(int u, bit is_a, output bit wrap);
    logic [1:0] md = mode_i[2*u +: 2];
    wrap = 0;
    if (md == 2'b11) md = 2'b00;
    case (md)
      2'b00:
        if (is_a) m_bit[u] ^= 1;
        else      m_quin[u] = (m_quin[u] >= 4) ? 0 : m_quin[u] + 1;
      2'b01:
        if (is_a) begin
          if (m_bit[u] == 1) begin
            m_bit[u] = 0;
            if (m_quin[u] >= 4) begin m_quin[u] = 0; wrap = 1; end
            else m_quin[u]++;
          end else m_bit[u] = 1;
        end
      default:
        if (!is_a) begin
          if (m_quin[u] >= 4) begin
            m_quin[u] = 0;
            if (m_bit[u] == 1) wrap = 1;
            m_bit[u] ^= 1;
          end else m_quin[u]++;
        end
    endcase
  endtask

  task automatic watch(int n);
    tc_seen[0] = 0; tc_seen[1] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tc_seen[0] += int'(tc_o[0]);
      tc_seen[1] += int'(tc_o[1]);
    end
  endtask

  task automatic check_units(string tag0, string tag1, int etc0, int etc1);
    check({tag0, " unit0 q"}, q_o[3:0], exp_nib(0));
    check({tag1, " unit1 q"}, q_o[7:4], exp_nib(1));
    check("R7 unit0 tc cycles", tc_seen[0], etc0);
    check("R7 unit1 tc cycles", tc_seen[1], etc1);
  endtask

  task automatic pulse(int u, bit is_a);
    bit w0 = 0, w1 = 0, wa, wb;
    string t0, t1;
    if (is_a) cnt_a_i[u] = 1'b1; else cnt_b_i[u] = 1'b1;
    repeat (4) @(negedge clk);
    if (is_a) cnt_a_i[u] = 1'b0; else cnt_b_i[u] = 1'b0;
    if (u == 1 && link_i[0]) begin
      t0 = "R10"; t1 = "R9";
    end else if (u == 0) begin
      m_step(0, is_a, w0);
      t0 = mode_tag(0);
      t1 = link_i[0] ? "R9" : "R10";
      if (w0 && link_i[0]) begin
        m_step(1, 1'b1, wa);
        m_step(1, 1'b0, wb);
        w1 = wa | wb;
      end
    end else begin
      m_step(1, is_a, w1);
      t0 = "R10"; t1 = mode_tag(1);
    end
    watch(6);
    check_units(t0, t1, int'(w0), int'(w1));
  endtask

  task automatic do_clear(int u);
    clr_i[u] = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 clear holds zero", (u == 0) ? q_o[3:0] : q_o[7:4], 0);
    clr_i[u] = 1'b0;
    m_bit[u] = 0; m_quin[u] = 0;
    watch(2);
    check_units("R10", "R10", 0, 0);
  endtask

  task automatic set_mode(int u, logic [1:0] m);
    mode_i[2*u +: 2] = m;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int u = 0; u < 2; u++) begin m_bit[u] = 0; m_quin[u] = 0; end
    cnt_a_i = 2'b11;
    repeat (3) @(negedge clk);
    check("R1 reset q", q_o, 0);
    check("R1 reset tc", tc_o, 0);
    rst_ni = 1'b1;
    cnt_a_i = 2'b00;
    watch(6);
    check_units("R1", "R1", 0, 0);

    // R11 latency: change due at third rising edge after the fall
    cnt_a_i[0] = 1'b1;
    repeat (4) @(negedge clk);
    cnt_a_i[0] = 1'b0;
    @(negedge clk); check("R11 unchanged after 1 edge", q_o[3:0], 0);
    @(negedge clk); check("R11 unchanged after 2 edges", q_o[3:0], 0);
    @(negedge clk); check("R11 changed after 3 edges", q_o[3:0], 1);
    m_bit[0] = 1;
    watch(3);

    // R3 wrap of the modulo-5 stage in split mode
    for (int i = 0; i < 5; i++) pulse(0, 1'b0);
    check("R3 quin back to 0", q_o[3:1], 0);

    // R4 full decade with terminal pulse
    do_clear(0);
    set_mode(0, 2'b01);
    for (int i = 0; i < 10; i++) pulse(0, 1'b1);
    check("R4 decade back to 0", q_o[3:0], 0);
    pulse(0, 1'b0);

    // R5 bi-quinary cycle
    set_mode(1, 2'b10);
    for (int i = 0; i < 10; i++) pulse(1, 1'b0);
    pulse(1, 1'b1);

    // R6 clear collides with a count strobe
    pulse(0, 1'b1);
    cnt_a_i[0] = 1'b1;
    repeat (4) @(negedge clk);
    cnt_a_i[0] = 1'b0;
    clr_i[0] = 1'b1;
    watch(5);
    clr_i[0] = 1'b0;
    m_bit[0] = 0; m_quin[0] = 0;
    watch(4);
    check("R6 clear beats strobe", q_o[3:0], 0);
    check("R6 no tc under clear", tc_seen[0], 0);

    // R9 divide-by-100 chain
    do_clear(1);
    set_mode(1, 2'b01);
    link_i = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 25; i++) pulse(0, 1'b1);
    pulse(1, 1'b1);

    // random mix
    for (int it = 0; it < 500; it++) begin
      int r = int'($urandom_range(0, 15));
      int u = int'($urandom_range(0, 1));
      if (r == 0) set_mode(u, 2'($urandom_range(0, 3)));
      else if (r == 1) begin link_i = ~link_i; @(negedge clk); end
      else if (r == 2) do_clear(u);
      else pulse(u, r[0]);
    end

    finished = 1;
    finish_run();
  end
endmodule